// File: doc/BRIEF.md
# Reflectable Playfield Serializer

This block holds a 20-bit coarse background pattern and turns it into one serial "playfield active" bit per pixel clock across the 160 visible pixels of a video line. Software loads the pattern through three byte-wide registers. One register carries only a nibble, and the three registers use different bit orders. A fourth register carries the mirror control bit. Each pattern bit is held for four pixel clocks, so the 20 bits cover the 80-pixel left half of the line.

A one-cycle start pulse marks the end of horizontal blank, and the scan begins on the next cycle. On the right half of the line the 20-bit sequence either repeats in the same order or runs in reverse, as selected by the mirror bit. The mirror bit is captured once at the middle of the line. Pattern registers may be rewritten at any time, and a change shows up at once in whatever part of the line has not yet been scanned. Outside the visible window the output stays low. Colour and priority are handled elsewhere.

Top module: `pf_serializer`

## Requirements
- R1: While reset is asserted the output is 0. After reset all pattern registers and the mirror bit read as 0, so a full line scanned without any write gives 0 on every pixel.
- R2: The visible window is the 160 cycles that follow the clock edge at which `line_start` is sampled high. The output is 0 in every other cycle.
- R3: A write with `wr_sel`=0 stores `wr_data[7:4]`. These four bits make up pattern bits 0 to 3 (bit 4 first, bit 7 last). `wr_data[3:0]` is ignored.
- R4: A write with `wr_sel`=1 stores all 8 bits. They make up pattern bits 4 to 11 in the order data bit 7 down to data bit 0.
- R5: A write with `wr_sel`=2 stores all 8 bits. They make up pattern bits 12 to 19 in the order data bit 0 up to data bit 7.
- R6: Pattern bit s is shown on visible pixels 4s to 4s+3 of the left half, and the output is constant inside each 4-pixel group.
- R7: When the mirror bit is 0, pixel 80+k shows the same value as pixel k for k in 0..79.
- R8: A write with `wr_sel`=3 stores `wr_data[0]` as the mirror bit. When it is 1, right-half group q (pixels 80+4q to 83+4q) shows pattern bit 19-q.
- R9: The mirror bit is sampled only at the edge that moves the scan from pixel 79 to pixel 80. A write to it during the right half does not affect that line, and it takes effect on the next line.
- R10: A pattern write lands at the next clock edge. The pixel after that edge already reflects the new value, even in the middle of a line.
- R11: A `line_start` pulse inside the visible window restarts the scan at pixel 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0,1,2 pattern, 3 mirror control |
| wr_data | input | 8 | Write data |
| line_start | input | 1 | One-cycle pulse at end of horizontal blank |
| pf_on | output | 1 | Playfield active for the current pixel |

## Verification
The scan is tried with single-bit patterns in each register, one per register at each end of its range. These show that each register lands in the right pattern slots and in the right order, and that the ignored nibble has no effect. A dense mixed pattern is run with and without the mirror bit, which separates repetition from reversal on the right half. Directed lines cover a pattern write in the middle of a line, a mirror write during the right half, and a restart pulse inside the visible window. Together these show when new state reaches the pixel stream.

// File: rtl/pf_serializer.sv
module pf_serializer #(
  parameter int PIX_PER_BIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       line_start,
  output logic       pf_on
);
  localparam int PF_BITS = 20;
  localparam int HALF    = PF_BITS * PIX_PER_BIT;
  localparam int LINE    = 2 * HALF;
  localparam int PW      = $clog2(LINE);
  localparam int SW      = $clog2(PF_BITS);

  logic [3:0]         pf_a;
  logic [7:0]         pf_b, pf_c;
  logic               mir_req, mir_cur;
  logic               active;
  logic [PW-1:0]      pos;
  logic [PF_BITS-1:0] seq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pf_a    <= '0;
      pf_b    <= '0;
      pf_c    <= '0;
      mir_req <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: pf_a    <= wr_data[7:4];
        2'd1: pf_b    <= wr_data;
        2'd2: pf_c    <= wr_data;
        default: mir_req <= wr_data[0];
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active  <= 1'b0;
      pos     <= '0;
      mir_cur <= 1'b0;
    end else if (line_start) begin
      active <= 1'b1;
      pos    <= '0;
    end else if (active) begin
      if (pos == PW'(LINE - 1)) active <= 1'b0;
      if (pos == PW'(HALF - 1)) mir_cur <= mir_req;
      pos <= pos + 1'b1;
    end

  assign seq[3:0]   = pf_a;
  assign seq[19:12] = pf_c;
  for (genvar j = 0; j < 8; j++) begin : g_mid
    assign seq[4 + j] = pf_b[7 - j];
  end

  logic          right;
  logic [PW-1:0] qpos, grp_w;
  logic [SW-1:0] grp, idx;

  assign right = pos >= PW'(HALF);
  assign qpos  = right ? pos - PW'(HALF) : pos;
  assign grp_w = qpos / PW'(PIX_PER_BIT);
  assign grp   = grp_w[SW-1:0];
  assign idx   = (right && mir_cur) ? SW'(PF_BITS - 1) - grp : grp;
  assign pf_on = active & seq[idx];
endmodule

// File: rtl/pf_serializer_chk.sv
module pf_serializer_chk #(
  parameter int PIX_PER_BIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       line_start,
  input logic       pf_on,
  input logic [3:0] pf_a,
  input logic [7:0] pf_b,
  input logic [7:0] pf_c
);
  localparam int LINE = 40 * PIX_PER_BIT;
  localparam int PW   = $clog2(LINE);

  logic [PW:0] vcnt;
  int          cpos;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vcnt <= '0;
    else if (line_start) vcnt <= (PW+1)'(LINE);
    else if (vcnt != 0) vcnt <= vcnt - 1'b1;

  assign cpos = LINE - int'(vcnt);

  // R2: dark outside the visible window
  p_blank_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt == 0) |-> !pf_on);

  // R6: constant inside a 4-pixel group unless a write just landed
  p_group_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt != 0 && (cpos % PIX_PER_BIT) != 0 && !$past(wr_en)) |-> $stable(pf_on));

  // R1: an empty pattern never lights a pixel
  p_empty_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_a == 4'h0 && pf_b == 8'h00 && pf_c == 8'h00) |-> !pf_on);

  // R8: a full pattern lights every visible pixel in either mode
  p_full_lit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt != 0 && pf_a == 4'hF && pf_b == 8'hFF && pf_c == 8'hFF) |-> pf_on);
endmodule

bind pf_serializer pf_serializer_chk #(.PIX_PER_BIT(PIX_PER_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .line_start(line_start),
  .pf_on(pf_on), .pf_a(pf_a), .pf_b(pf_b), .pf_c(pf_c)
);

// File: tb/pf_serializer_test.sv
module pf_serializer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       line_start = 1'b0;
  logic       pf_on;

  int n_checks = 0;
  int n_errors = 0;

  pf_serializer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .line_start(line_start), .pf_on(pf_on)
  );

  always #2.5 clk = ~clk;

  // {reg0, reg1, reg2, mirror, expected left sequence with slot 0 at bit 19}
  localparam logic [44:0] VEC [9] = '{
    {8'hF0, 8'h00, 8'h00, 1'b0, 20'hF0000},
    {8'h10, 8'h00, 8'h00, 1'b1, 20'h80000},
    {8'h0F, 8'h00, 8'h00, 1'b0, 20'h00000},
    {8'h00, 8'h80, 8'h00, 1'b0, 20'h08000},
    {8'h00, 8'h01, 8'h00, 1'b1, 20'h00100},
    {8'h00, 8'h00, 8'h01, 1'b0, 20'h00080},
    {8'h00, 8'h00, 8'h80, 1'b1, 20'h00001},
    {8'hA0, 8'hC3, 8'h0E, 1'b0, 20'h5C370},
    {8'hA0, 8'hC3, 8'h0E, 1'b1, 20'h5C370}
  };

  function automatic logic [159:0] exp_line(input logic [19:0] left, input logic mir);
    logic [159:0] r;
    for (int p = 0; p < 160; p++) begin
      int s;
      if (p < 80) s = p / 4;
      else s = mir ? 19 - (p - 80) / 4 : (p - 80) / 4;
      r[p] = left[19 - s];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [159:0] got, input logic [159:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_line();
    @(negedge clk);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic capture(output logic [159:0] got);
    start_line();
    for (int p = 0; p < 160; p++) begin
      got[p] = pf_on;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [159:0] got, exp;
    repeat (3) @(negedge clk);
    check("R1 output in reset", {159'd0, pf_on}, 160'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 idle before line", {159'd0, pf_on}, 160'd0);
    capture(got);
    check("R1 cleared registers", got, 160'd0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 9; i++) begin
      wr(2'd0, VEC[i][44:37]);
      wr(2'd1, VEC[i][36:29]);
      wr(2'd2, VEC[i][28:21]);
      wr(2'd3, {7'd0, VEC[i][20]});
      capture(got);
      check($sformatf("R3/R4/R5/R6/R7/R8 vector %0d", i), got,
            exp_line(VEC[i][19:0], VEC[i][20]));
      check("R2 dark after line end", {159'd0, pf_on}, 160'd0);
    end

    // R10: mid-line write to reg1 at pixel 20
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    start_line();
    for (int p = 0; p < 160; p++) begin
      got[p] = pf_on;
      if (p == 20) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'hFF; end
      @(negedge clk);
      wr_en = 1'b0;
    end
    exp = exp_line(20'h0FF00, 1'b0);
    for (int p = 0; p <= 20; p++) exp[p] = 1'b0;
    check("R10 mid-line write", got, exp);

    // R9: mirror written during right half applies only to next line
    wr(2'd0, 8'h10); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    start_line();
    for (int p = 0; p < 160; p++) begin
      got[p] = pf_on;
      if (p == 90) begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h01; end
      @(negedge clk);
      wr_en = 1'b0;
    end
    check("R9 late mirror write ignored", got, exp_line(20'h80000, 1'b0));
    capture(got);
    check("R9 mirror on next line", got, exp_line(20'h80000, 1'b1));

    // R11: restart inside the visible window
    wr(2'd3, 8'h00);
    start_line();
    for (int p = 0; p < 50; p++) @(negedge clk);
    check("R11 before restart", {159'd0, pf_on}, 160'd0);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int p = 0; p < 160; p++) begin
      got[p] = pf_on;
      @(negedge clk);
    end
    check("R11 restarted scan", got, exp_line(20'h80000, 1'b0));
    check("R2 dark after restarted line", {159'd0, pf_on}, 160'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule